// File: doc/BRIEF.md
# Buffered Serial Peripheral Port

This block is a full-duplex serial peripheral port that runs either as the clock-driving master or as a clocked slave. One shift register sits between two 8-word queues. The transmit queue collects words that the host pushes. The receive queue holds completed words until the host pops them. Words are moved most significant bit first. Transmit and receive happen together: every serial clock edge that launches an output bit is paired with an edge that captures an input bit.

In master mode the port makes its own serial clock from the system clock. The divide ratio is the product of two settings: a coarse ratio of 1, 4, 16 or 64 and a fine ratio of 1 to 8. A transfer starts as soon as a word is waiting and both enable bits are set. In slave mode the port follows an external serial clock and an active-low select line. These inputs are synchronised into the system clock domain, so the external clock must be several times slower than the system clock. A sticky overflow flag and a sticky completion flag report receive-side events. An interrupt output combines the completion flag with an enable bit.

Top module: `spi_port`

## Requirements
- R1: Each queue holds 8 words. `tx_full` is 1 while 8 words wait to be sent. A host write made while the transmit queue is full is discarded.
- R2: In master mode, each half-period of `sck_o` lasts D system clocks. D = 4^`cfg_pri` × (`cfg_sec` + 1), so `cfg_pri` = 0..3 gives 1, 4, 16, 64 and `cfg_sec` = 0..7 gives 1..8.
- R3: Serial activity takes place only while both `cfg_en` and `cfg_buf_en` are 1. In master mode a word then starts without further action whenever the transmit queue is not empty.
- R4: `sck_o` rests at `cfg_cpol` between transfers. With `cfg_out_edge` = 1, the most significant bit is on `sdo_o` before the first clock edge, input is captured on the first edge (idle-to-active) and output changes on the second (active-to-idle). With `cfg_out_edge` = 0, output changes on the idle-to-active edge and input is captured on the active-to-idle edge. Data moves MSB first in both directions at the same time.
- R5: A word that completes while the receive queue is full is discarded and sets `rx_ovf`. `rx_ovf` stays 1 until `ovf_clr` is pulsed.
- R6: In slave mode (`cfg_master` = 0), the port shifts the head of the transmit queue out on `sdo_o` using edges of `sck_i`, sends zeros if the queue is empty, and stores each received 8-bit word in the receive queue.
- R7: In slave mode with the select line in use, `ss_n_i` = 1 turns `sdo_oe` off, and clock edges seen during that time do not advance the bit count. The next word after the select goes low therefore starts from bit 7.
- R8: In slave mode with `cfg_out_edge` = 1, the select line is in use even when `cfg_ss_en` = 0. With `cfg_out_edge` = 0 it is in use only when `cfg_ss_en` = 1.
- R9: Each word stored in the receive queue sets an internal completion flag. The flag stays set until `irq_clr` is pulsed. `irq` = flag AND `cfg_irq_en`.
- R10: `rx_empty` is 1 when no received word waits. `busy` is 1 while a master word is being shifted, or while a slave word is partly received.
- R11: After reset, every queue is empty, both flags are clear, `busy` is 0 and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Global port enable |
| cfg_buf_en | input | 1 | Queued operation enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_out_edge | input | 1 | 1 = output changes on the active-to-idle edge |
| cfg_ss_en | input | 1 | Use the slave select input |
| cfg_pri | input | 2 | Coarse clock ratio select (1/4/16/64) |
| cfg_sec | input | 3 | Fine clock ratio, ratio = value + 1 |
| cfg_irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | W | Word to transmit |
| rd_en | input | 1 | Pop the receive queue |
| rd_data | output | W | Head of the receive queue |
| ovf_clr | input | 1 | Clear the overflow flag |
| irq_clr | input | 1 | Clear the completion flag |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | A word is in progress |
| rx_ovf | output | 1 | Sticky receive overflow |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock output (master) |
| sck_i | input | 1 | Serial clock input (slave) |
| ss_n_i | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo_o` |

## Verification
The embedded properties check on every cycle that a full transmit queue does not grow, and that the receive queue never holds more than it can. They also check that both sticky flags stay set until their clear strobe arrives. Further properties check that no shift runs while the port is disabled, that the master clock does not move between divider terminal counts, and that an inactive select keeps the bit counter at zero. The correctness of the data itself can only be shown by the bench scenarios. These cover the MSB-first order in both clock modes, the measured half-period for several ratio settings, the words kept and dropped around a full receive queue, and slave transfers against an external master model, including edges sent while the select was inactive.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_buf_en,
  input  logic         cfg_master,
  input  logic         cfg_cpol,
  input  logic         cfg_out_edge,
  input  logic         cfg_ss_en,
  input  logic [1:0]   cfg_pri,
  input  logic [2:0]   cfg_sec,
  input  logic         cfg_irq_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic         ovf_clr,
  input  logic         irq_clr,
  output logic         tx_full,
  output logic         rx_empty,
  output logic         busy,
  output logic         rx_ovf,
  output logic         irq,
  output logic         sck_o,
  input  logic         sck_i,
  input  logic         ss_n_i,
  input  logic         sdi,
  output logic         sdo_o,
  output logic         sdo_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int HW = $clog2(2 * W);
  localparam int DW = 10;

  logic [W-1:0]  tx_mem [DEPTH];
  logic [W-1:0]  rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [W-1:0]  sr;
  logic [HW-1:0] hc;
  logic [DW-1:0] div, div_n;
  logic          run, sdo_q, sck_q, irq_flag;
  logic [2:0]    sck_m;
  logic [1:0]    ss_m, sdi_m;

  wire active   = cfg_en & cfg_buf_en;
  wire ss_use   = cfg_ss_en | cfg_out_edge;
  wire ss_block = !cfg_master && ss_use && ss_m[1];
  wire tx_any   = (tx_cnt != '0);
  wire [W-1:0] tx_head = tx_mem[tx_rp];
  wire [W-1:0] pre     = tx_any ? tx_head : '0;

  assign div_n = (DW'(1) << {cfg_pri, 1'b0}) * (DW'(cfg_sec) + DW'(1));

  wire m_edge  = cfg_master && active && run && (div == div_n - DW'(1));
  wire s_edge  = !cfg_master && active && !ss_block && (sck_m[1] ^ sck_m[2]);
  wire ev      = m_edge | s_edge;
  wire capture = cfg_out_edge ? !hc[0] : hc[0];
  wire last    = (hc == HW'(2 * W - 1));
  wire sdi_v   = cfg_master ? sdi : sdi_m[1];
  wire [W-1:0] word = capture ? {sr[W-2:0], sdi_v} : sr;
  wire done    = ev && last;

  wire m_start   = cfg_master && active && !run && tx_any;
  wire s_preload = !cfg_master && !ev && (hc == '0);
  wire tx_pop    = m_start || (!cfg_master && ev && (hc == '0) && tx_any);
  wire tx_push   = wr_en && (tx_cnt != CW'(DEPTH));
  wire rx_pop    = rd_en && (rx_cnt != '0);
  wire rx_push   = done && ((rx_cnt != CW'(DEPTH)) || rx_pop);

  assign tx_full  = (tx_cnt == CW'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign rd_data  = rx_mem[rx_rp];
  assign busy     = cfg_master ? run : (hc != '0);
  assign irq      = irq_flag & cfg_irq_en;
  assign sck_o    = sck_q;
  assign sdo_o    = sdo_q;
  assign sdo_oe   = active && (cfg_master || !ss_block);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_m <= '0; ss_m <= 2'b11; sdi_m <= '0;
    end else begin
      sck_m <= {sck_m[1:0], sck_i};
      ss_m  <= {ss_m[0], ss_n_i};
      sdi_m <= {sdi_m[0], sdi};
    end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= wr_data;
    if (rx_push) rx_mem[rx_wp] <= word;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      rx_ovf <= 1'b0; irq_flag <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      if (done && !rx_push) rx_ovf <= 1'b1;
      else if (ovf_clr)     rx_ovf <= 1'b0;
      if (rx_push)      irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; hc <= '0; div <= '0; sr <= '0; sdo_q <= 1'b0; sck_q <= 1'b0;
    end else begin
      if (!(cfg_master && run && active)) sck_q <= cfg_cpol;
      if (!active) begin
        run <= 1'b0; hc <= '0; div <= '0;
      end else if (cfg_master) begin
        if (m_start) begin
          run <= 1'b1; hc <= '0; div <= '0; sr <= tx_head;
          if (cfg_out_edge) sdo_q <= tx_head[W-1];
        end else if (run) begin
          if (m_edge) begin
            div <= '0; sck_q <= ~sck_q;
          end else div <= div + 1'b1;
        end
      end else begin
        run <= 1'b0; div <= '0;
        if (ss_block) hc <= '0;
        else if (s_preload) begin
          sr <= pre;
          if (cfg_out_edge) sdo_q <= pre[W-1];
        end
      end
      if (ev) begin
        if (capture) sr <= word;
        else         sdo_q <= sr[W-1];
        hc <= last ? '0 : hc + 1'b1;
        if (last) run <= 1'b0;
      end
    end

  assert_tx_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH) && wr_en && !tx_pop) |=> (tx_cnt == CW'(DEPTH) && $stable(tx_wp)));

  always_ff @(posedge clk)
    if (rst_n) assert_rx_bound_R1: assert (rx_cnt <= CW'(DEPTH));

  assert_div_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && active && run && !m_edge) |=> $stable(sck_o));

  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!run && hc == '0));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !ovf_clr) |=> rx_ovf);

  assert_ss_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_block |=> (hc == '0));

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);
endmodule

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_buf_en = 0, cfg_master = 1, cfg_cpol = 0, cfg_out_edge = 1;
  logic cfg_ss_en = 0, cfg_irq_en = 0;
  logic [1:0] cfg_pri = 0;
  logic [2:0] cfg_sec = 0;
  logic wr_en = 0, rd_en = 0, ovf_clr = 0, irq_clr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic tx_full, rx_empty, busy, rx_ovf, irq, sck_o, sdo_o, sdo_oe;
  logic sck_b = 0, ss_b = 1, sdi_b = 0, loop = 1;
  wire  sdi = loop ? sdo_o : sdi_b;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_port u0 (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_buf_en(cfg_buf_en),
    .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_out_edge(cfg_out_edge),
    .cfg_ss_en(cfg_ss_en), .cfg_pri(cfg_pri), .cfg_sec(cfg_sec), .cfg_irq_en(cfg_irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ovf_clr(ovf_clr), .irq_clr(irq_clr), .tx_full(tx_full), .rx_empty(rx_empty),
    .busy(busy), .rx_ovf(rx_ovf), .irq(irq), .sck_o(sck_o), .sck_i(sck_b),
    .ss_n_i(ss_b), .sdi(sdi), .sdo_o(sdo_o), .sdo_oe(sdo_oe));

  function automatic int half_len(input int pri, input int sec);
    return (1 << (2 * pri)) * (sec + 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); d = rd_data; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (busy) q = 0; else q++;
    end
  endtask

  task automatic slave_word(input logic [7:0] mosi, output logic [7:0] miso);
    miso = 0;
    if (cfg_out_edge) sdi_b = mosi[7];
    @(negedge clk); ss_b = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      logic lead, cap;
      lead = (i % 2 == 0);
      cap  = cfg_out_edge ? lead : !lead;
      if (cap) miso[7 - i / 2] = sdo_o;
      sck_b = ~sck_b;
      if (!cap) begin
        if (cfg_out_edge) begin
          if ((i + 1) / 2 < 8) sdi_b = mosi[7 - (i + 1) / 2];
        end else sdi_b = mosi[7 - i / 2];
      end
      repeat (10) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, m, words[9];
    int prev, cnt;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 rx_empty", rx_empty, 1);
    chk("R11 tx_full", tx_full, 0);
    chk("R11 busy", busy, 0);
    chk("R11 flags", {rx_ovf, irq}, 0);
    chk("R11 sdo_oe", sdo_oe, 0);

    // R3: one enable alone does not start a master word
    cfg_en = 1; cfg_pri = 1; cfg_sec = 3;
    push(8'hA5);
    repeat (40) @(negedge clk);
    chk("R3 no shift with buffer enable off", {busy, sck_o}, 0);
    cfg_buf_en = 1;
    repeat (3) @(negedge clk);
    chk("R10 busy during master word", busy, 1);
    chk("R4 MSB on sdo before first edge", sdo_o, 1);
    wait_idle();
    chk("R10 rx_empty after word", rx_empty, 0);
    pop(d);
    chk("R4 loopback word", d, 8'hA5);
    chk("R9 irq masked", irq, 0);
    @(negedge clk); cfg_irq_en = 1;
    @(negedge clk);
    chk("R9 irq after enable", irq, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0; @(negedge clk);
    chk("R9 irq after clear", irq, 0);

    // R2 divider half-period
    for (int k = 0; k < 4; k++) begin
      int pr, se;
      pr = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : 0;
      se = (k == 0) ? 0 : (k == 1) ? 2 : (k == 2) ? 1 : 7;
      cfg_pri = pr[1:0]; cfg_sec = se[2:0];
      push(8'h3C);
      prev = sck_o;
      while (sck_o == prev) @(negedge clk);
      prev = sck_o; cnt = 0;
      while (sck_o == prev) begin @(negedge clk); cnt++; end
      chk("R2 half period", cnt, half_len(pr, se));
      wait_idle();
      pop(d);
    end

    // R4 idle level and random loopback in both clock modes
    cfg_cpol = 1; repeat (3) @(negedge clk);
    chk("R4 idle level cpol=1", sck_o, 1);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] w;
      w = 8'($urandom);
      cfg_cpol = 1'($urandom); cfg_out_edge = 1'($urandom);
      cfg_pri = 2'($urandom % 2); cfg_sec = 3'($urandom);
      repeat (2) @(negedge clk);
      push(w);
      wait_idle();
      chk("R4 idle after word", sck_o, cfg_cpol);
      pop(d);
      chk("R4 random loopback", d, w);
    end

    // R1/R5 queue limits
    cfg_pri = 0; cfg_sec = 0; cfg_buf_en = 0; cfg_irq_en = 0;
    for (int k = 0; k < 9; k++) begin words[k] = 8'($urandom); push(words[k]); end
    chk("R1 tx_full after 8", tx_full, 1);
    cfg_buf_en = 1;
    wait_idle();
    chk("R1 ninth write dropped", rx_ovf, 0);
    push(8'h77);
    wait_idle();
    chk("R5 overflow set", rx_ovf, 1);
    for (int k = 0; k < 8; k++) begin
      pop(d);
      chk("R5 kept words", d, words[k]);
    end
    chk("R10 rx_empty after drain", rx_empty, 1);
    chk("R5 overflow sticky", rx_ovf, 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0; @(negedge clk);
    chk("R5 overflow cleared", rx_ovf, 0);

    // R6 slave transfers
    loop = 0; cfg_master = 0; cfg_ss_en = 1; ss_b = 1;
    for (int k = 0; k < 10; k++) begin
      logic [7:0] tw, mw;
      tw = 8'($urandom); mw = 8'($urandom);
      cfg_cpol = 1'($urandom); cfg_out_edge = 1'($urandom);
      sck_b = cfg_cpol;
      repeat (6) @(negedge clk);
      push(tw);
      repeat (4) @(negedge clk);
      slave_word(mw, m);
      chk("R6 slave shifted out", m, tw);
      pop(d);
      chk("R6 slave received", d, mw);
      ss_b = 1;
      repeat (4) @(negedge clk);
    end

    // R7 edges while select inactive are ignored
    cfg_out_edge = 0; cfg_cpol = 0; sck_b = 0;
    repeat (6) @(negedge clk);
    chk("R7 sdo_oe off while deselected", sdo_oe, 0);
    for (int k = 0; k < 4; k++) begin sck_b = ~sck_b; repeat (10) @(negedge clk); end
    chk("R7 no word from deselected edges", {rx_empty, busy}, 2'b10);
    push(8'h5A);
    slave_word(8'hC3, m);
    chk("R7 word after select", m, 8'h5A);
    pop(d);
    chk("R7 received after select", d, 8'hC3);
    chk("R7 single word", rx_empty, 1);

    // R8 select interlock
    ss_b = 1; cfg_ss_en = 0; cfg_out_edge = 1;
    repeat (4) @(negedge clk);
    chk("R8 select honoured with out_edge=1", sdo_oe, 0);
    ss_b = 0; repeat (4) @(negedge clk);
    chk("R8 driven when selected", sdo_oe, 1);
    ss_b = 1; cfg_out_edge = 0; repeat (4) @(negedge clk);
    chk("R8 select ignored with out_edge=0", sdo_oe, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule